// File: doc/BRIEF.md
# Flash command sequence interpreter

This block models the command front end of a NOR flash device as plain synchronous logic. The host issues bus writes, each an address and a data word, over a valid/ready channel. The block follows the multi-write command sequences and picks what a read returns: array data, status data or autoselect data. It also issues operation requests to an external engine that carries out programming and erasing, and it tracks which sectors an erase has marked so that reads can be routed correctly while that erase is suspended.

A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The host holds `wr_valid`, `wr_addr` and `wr_data` steady until that edge. `wr_ready` is low while a program runs and while an operation request waits to be accepted.

Operation requests leave on a second valid/ready channel. `op_valid` and its fields hold until the engine raises `op_ready`. The engine reports the end of an operation with a one-cycle `eng_done` pulse, or a timeout with a one-cycle `eng_fail` pulse. The read path is combinational: `rd_mode` follows `rd_addr` and the current state within the same cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and when `rst_n` is asserted at any later point, `rd_mode` is 0 (array) for every address, `op_valid` is 0, `sect_mask` is 0 and `wr_ready` is 1.
- R2: A command byte is honoured only after a two-write unlock prefix. The first write is data 0xAA at key address 0x555 and the second is data 0x55 at key address 0x2AA. Key addresses are compared on `wr_addr[10:0]` and command bytes on `wr_data[7:0]`. After the prefix, byte 0x90, 0xA0 or 0x80 written at 0x555 selects autoselect, program or erase setup. Erase setup then needs a second prefix followed by 0x30 at an address in the target sector, or 0x10 at 0x555.
- R3: A write with the wrong address, the wrong data or the wrong position in a sequence abandons the sequence without issuing any request. The block returns to its base mode, which is array read, or the suspended mode if an erase is suspended.
- R4: A write of 0xF0 at any address returns the block to its base mode from every state except a running program or erase.
- R5: In autoselect mode, `rd_mode` is 2 for every address and every write other than 0xF0 is ignored.
- R6: In the program sequence, the first write after 0xA0 issues a request with kind 0 carrying that write's address and data. While the program runs, `rd_mode` is 1 and `wr_ready` is 0. `eng_done` returns the block to its base mode.
- R7: A sector erase sets bit `wr_addr[ADDR_W-1 -: SECT_W]` of `sect_mask`. A chip erase sets every bit. Either one issues a request with kind 1. While the erase runs, `rd_mode` is 1 and every write other than 0xB0 is ignored. `eng_done` returns the block to array read and clears `sect_mask`.
- R8: During a running erase, 0xB0 at any address issues a request with kind 2 and enters the suspended mode. In that mode, reads in a marked sector give `rd_mode` 1 and all other reads give 0.
- R9: A program may run while an erase is suspended. When it completes, the block is back in the suspended mode with the same read rule.
- R10: In the suspended mode, 0x30 at any address issues a request with kind 3 and resumes the erase. `rd_mode` is then 1 everywhere.
- R11: `eng_fail` during a running operation enters a fault mode. In fault mode `rd_mode` is 1 everywhere and only 0xF0 has an effect: it restores array read, clears `sect_mask` and drops the suspension.
- R12: `op_valid`, `op_kind`, `op_addr` and `op_data` hold until `op_ready` is high. `wr_ready` is 0 while a request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Bus write can be taken this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low 8 bits carry the command byte |
| rd_addr | input | ADDR_W | Address of the current read |
| rd_mode | output | 2 | 0 array, 1 status, 2 autoselect |
| eng_done | input | 1 | Engine finished the running operation (one-cycle pulse) |
| eng_fail | input | 1 | Engine timed out (one-cycle pulse) |
| op_valid | output | 1 | Operation request pending |
| op_ready | input | 1 | Engine takes the request |
| op_kind | output | 2 | 0 program, 1 erase, 2 suspend, 3 resume |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | DATA_W | Program data of the request |
| sect_mask | output | 2**SECT_W | Sectors marked by the current erase |

## Verification
The assertions check the request channel on every cycle: they require that a stalled request keeps its fields and blocks writes, that a program request blocks writes, and that an erase request always comes with a non-empty sector mask. They also check that autoselect mode can only be left through a reset-command write. Whether a corrupted or reordered sequence really falls back to the base mode can only be shown by the bench scenarios. The same holds for the sector-dependent read routing while an erase is suspended, for a program completing inside a suspension, and for recovery from a fault.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_STATUS  = 2'd1,
    RM_AUTOSEL = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    OPK_PROG    = 2'd0,
    OPK_ERASE   = 2'd1,
    OPK_SUSPEND = 2'd2,
    OPK_RESUME  = 2'd3
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_PROG_ARG,
    ST_ERS_SETUP,
    ST_ERS_KEY1,
    ST_ERS_KEY2,
    ST_AUTOSEL,
    ST_PROG_RUN,
    ST_ERS_RUN,
    ST_SUSPENDED,
    ST_FAULT
  } seq_state_e;

  localparam int KEY_AW = 11;
  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [7:0] B_KEY_A    = 8'hAA;
  localparam logic [7:0] B_KEY_B    = 8'h55;
  localparam logic [7:0] B_RESET    = 8'hF0;
  localparam logic [7:0] B_AUTOSEL  = 8'h90;
  localparam logic [7:0] B_PROGRAM  = 8'hA0;
  localparam logic [7:0] B_ERS_SET  = 8'h80;
  localparam logic [7:0] B_ERS_SECT = 8'h30;
  localparam logic [7:0] B_ERS_CHIP = 8'h10;
  localparam logic [7:0] B_SUSPEND  = 8'hB0;
  localparam logic [7:0] B_RESUME   = 8'h30;

endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
(
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [7:0]        cbyte,
  output logic              at_key_a,
  output logic              is_key_a,
  output logic              is_key_b,
  output logic              is_reset
);
  always_comb begin
    at_key_a = (key_addr == KEY_ADDR_A);
    is_key_a = at_key_a && (cbyte == B_KEY_A);
    is_key_b = (key_addr == KEY_ADDR_B) && (cbyte == B_KEY_B);
    is_reset = (cbyte == B_RESET);
  end
endmodule

// File: rtl/flash_sect_track.sv
module flash_sect_track #(
  parameter int SECT_W = 4,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_one,
  input  logic              mark_all,
  input  logic              clear_all,
  input  logic [SECT_W-1:0] mark_idx,
  input  logic [SECT_W-1:0] look_idx,
  output logic [NSECT-1:0]  mask,
  output logic              hit
);
  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask[s] <= 1'b0;
      else if (clear_all)
        mask[s] <= 1'b0;
      else if (mark_all || (mark_one && mark_idx == SECT_W'(s)))
        mask[s] <= 1'b1;
    end
  end

  assign hit = mask[look_idx];
endmodule

// File: rtl/flash_op_port.sv
module flash_op_port
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_kind_e          l_kind,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_data,
  input  logic              op_ready,
  output logic              op_valid,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              stall
);
  assign stall = op_valid && !op_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= OPK_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else if (launch) begin
      op_valid <= 1'b1;
      op_kind  <= l_kind;
      op_addr  <= l_addr;
      op_data  <= l_data;
    end else if (op_ready) begin
      op_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [1:0]             rd_mode,
  input  logic                   eng_done,
  input  logic                   eng_fail,
  output logic                   op_valid,
  input  logic                   op_ready,
  output logic [1:0]             op_kind,
  output logic [ADDR_W-1:0]      op_addr,
  output logic [DATA_W-1:0]      op_data,
  output logic [(1<<SECT_W)-1:0] sect_mask
);
  localparam int NSECT = 1 << SECT_W;

  seq_state_e state, nxt;
  logic       susp_q, susp_set, susp_clr;
  logic       fire, stall;
  logic       at_key_a, is_key_a, is_key_b, is_reset;
  logic [7:0] cbyte;
  logic       launch;
  op_kind_e   l_kind, kind_q;
  logic       mark_one, mark_all, clear_all, sect_hit;
  seq_state_e base;

  assign cbyte = wr_data[7:0];
  assign fire  = wr_valid && wr_ready;
  assign base  = susp_q ? ST_SUSPENDED : ST_READ;

  flash_cmd_dec u_dec (
    .key_addr (wr_addr[KEY_AW-1:0]),
    .cbyte    (cbyte),
    .at_key_a (at_key_a),
    .is_key_a (is_key_a),
    .is_key_b (is_key_b),
    .is_reset (is_reset)
  );

  flash_sect_track #(.SECT_W(SECT_W)) u_sect (
    .clk       (clk),
    .rst_n     (rst_n),
    .mark_one  (mark_one),
    .mark_all  (mark_all),
    .clear_all (clear_all),
    .mark_idx  (wr_addr[ADDR_W-1 -: SECT_W]),
    .look_idx  (rd_addr[ADDR_W-1 -: SECT_W]),
    .mask      (sect_mask),
    .hit       (sect_hit)
  );

  flash_op_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_op (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .l_kind   (l_kind),
    .l_addr   (wr_addr),
    .l_data   (wr_data),
    .op_ready (op_ready),
    .op_valid (op_valid),
    .op_kind  (kind_q),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .stall    (stall)
  );
  assign op_kind = kind_q;

  assign wr_ready = (state != ST_PROG_RUN) && !stall;

  always_comb begin
    nxt       = state;
    launch    = 1'b0;
    l_kind    = OPK_PROG;
    mark_one  = 1'b0;
    mark_all  = 1'b0;
    clear_all = 1'b0;
    susp_set  = 1'b0;
    susp_clr  = 1'b0;
    unique case (state)
      ST_PROG_RUN: begin
        if (eng_fail)      nxt = ST_FAULT;
        else if (eng_done) nxt = base;
      end
      ST_ERS_RUN: begin
        if (eng_fail) nxt = ST_FAULT;
        else if (eng_done) begin
          nxt       = ST_READ;
          clear_all = 1'b1;
        end else if (fire && cbyte == B_SUSPEND) begin
          nxt      = ST_SUSPENDED;
          launch   = 1'b1;
          l_kind   = OPK_SUSPEND;
          susp_set = 1'b1;
        end
      end
      ST_READ, ST_SUSPENDED: if (fire) begin
        if (is_reset) nxt = base;
        else if (state == ST_SUSPENDED && cbyte == B_RESUME) begin
          nxt      = ST_ERS_RUN;
          launch   = 1'b1;
          l_kind   = OPK_RESUME;
          susp_clr = 1'b1;
        end else if (is_key_a) nxt = ST_KEY1;
        else nxt = base;
      end
      ST_KEY1: if (fire) nxt = is_key_b ? ST_KEY2 : base;
      ST_KEY2: if (fire) begin
        nxt = base;
        if (at_key_a) begin
          if (cbyte == B_PROGRAM)                  nxt = ST_PROG_ARG;
          else if (cbyte == B_AUTOSEL && !susp_q)  nxt = ST_AUTOSEL;
          else if (cbyte == B_ERS_SET && !susp_q)  nxt = ST_ERS_SETUP;
        end
      end
      ST_PROG_ARG: if (fire) begin
        if (is_reset) nxt = base;
        else begin
          nxt    = ST_PROG_RUN;
          launch = 1'b1;
          l_kind = OPK_PROG;
        end
      end
      ST_ERS_SETUP: if (fire) nxt = is_key_a ? ST_ERS_KEY1 : ST_READ;
      ST_ERS_KEY1:  if (fire) nxt = is_key_b ? ST_ERS_KEY2 : ST_READ;
      ST_ERS_KEY2: if (fire) begin
        nxt = ST_READ;
        if (cbyte == B_ERS_SECT) begin
          nxt      = ST_ERS_RUN;
          launch   = 1'b1;
          l_kind   = OPK_ERASE;
          mark_one = 1'b1;
        end else if (cbyte == B_ERS_CHIP && at_key_a) begin
          nxt      = ST_ERS_RUN;
          launch   = 1'b1;
          l_kind   = OPK_ERASE;
          mark_all = 1'b1;
        end
      end
      ST_AUTOSEL: if (fire && is_reset) nxt = ST_READ;
      ST_FAULT: if (fire && is_reset) begin
        nxt       = ST_READ;
        clear_all = 1'b1;
        susp_clr  = 1'b1;
      end
      default: nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_READ;
      susp_q <= 1'b0;
    end else begin
      state <= nxt;
      if (susp_set)      susp_q <= 1'b1;
      else if (susp_clr) susp_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state)
      ST_AUTOSEL:                         rd_mode = RM_AUTOSEL;
      ST_PROG_RUN, ST_ERS_RUN, ST_FAULT:  rd_mode = RM_STATUS;
      default: rd_mode = (susp_q && sect_hit) ? RM_STATUS : RM_ARRAY;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [DATA_W-1:0]      wr_data,
  input logic [1:0]             rd_mode,
  input logic                   op_valid,
  input logic                   op_ready,
  input logic [1:0]             op_kind,
  input logic [ADDR_W-1:0]      op_addr,
  input logic [(1<<SECT_W)-1:0] sect_mask
);
  logic take_f0;
  assign take_f0 = wr_valid && wr_ready && (wr_data[7:0] == 8'hF0);

  // R12
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_addr));

  // R12
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |-> !wr_ready);

  // R6
  prog_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'd0 |-> !wr_ready);

  // R5
  autosel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode == 2'd2 && !take_f0 |=> rd_mode == 2'd2);

  // R7
  erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'd1 |-> sect_mask != '0);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .rd_mode   (rd_mode),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_kind   (op_kind),
  .op_addr   (op_addr),
  .sect_mask (sect_mask)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/100ps
module flash_cmd_seq_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_mode;
  logic          eng_done = 1'b0;
  logic          eng_fail = 1'b0;
  logic          op_valid;
  logic          op_ready = 1'b1;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [15:0]   sect_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_mode(rd_mode),
    .eng_done(eng_done), .eng_fail(eng_fail), .op_valid(op_valid),
    .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .sect_mask(sect_mask)
  );

  typedef struct packed {
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0]  m;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{20'h00555, 16'h00AA, 2'd0}, '{20'h002AA, 16'h0055, 2'd0},
    '{20'h00555, 16'h0090, 2'd2}, '{20'h00123, 16'h0012, 2'd2},
    '{20'h00555, 16'h00A0, 2'd2}, '{20'h00007, 16'h00F0, 2'd0},
    '{20'h00555, 16'h00AA, 2'd0}, '{20'h002AB, 16'h0055, 2'd0},
    '{20'h00555, 16'h0090, 2'd0}, '{20'h002AA, 16'h0055, 2'd0},
    '{20'h00555, 16'h00AA, 2'd0}, '{20'h00555, 16'h0090, 2'd0},
    '{20'h00555, 16'h00AA, 2'd0}, '{20'h002AA, 16'h0054, 2'd0},
    '{20'h00555, 16'h0090, 2'd0}, '{20'h00555, 16'h00AA, 2'd0},
    '{20'h00007, 16'h00F0, 2'd0}, '{20'h002AA, 16'h0055, 2'd0},
    '{20'h00555, 16'h0090, 2'd0}, '{20'h00555, 16'h00AA, 2'd0},
    '{20'h002AA, 16'h0055, 2'd0}, '{20'h00555, 16'h0080, 2'd0},
    '{20'h00555, 16'h00AA, 2'd0}, '{20'h002AA, 16'h0055, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic mode_at(input logic [AW-1:0] a, input string req, input int exp);
    rd_addr = a;
    #1;
    chk(req, int'(rd_mode), exp);
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
  endtask

  task automatic pulse(input bit fail);
    @(negedge clk);
    if (fail) eng_fail = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_fail = 1'b0; eng_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    mode_at(20'h30000, "R1 mode", 0);
    chk("R1 op_valid", int'(op_valid), 0);
    chk("R1 mask", int'(sect_mask), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: table of sequences, mode and no request after each write
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      mode_at(20'h00000, "R2/R3 table mode", int'(VEC[i].m));
      chk("R3 table no request", int'(op_valid), 0);
    end
    wr(20'h00555, 16'h0020);             // R3 bad erase byte
    mode_at(20'h0, "R3 bad erase code", 0);
    chk("R3 no erase request", int'(op_valid), 0);

    // R6 program
    unlock(); wr(20'h00555, 16'h00A0);
    wr(20'h12345, 16'hBEEF);
    chk("R6 op_valid", int'(op_valid), 1);
    chk("R6 kind", int'(op_kind), 0);
    chk("R6 addr", int'(op_addr), 'h12345);
    chk("R6 data", int'(op_data), 'hBEEF);
    mode_at(20'h0, "R6 status while running", 1);
    @(negedge clk);
    chk("R6 wr_ready low", int'(wr_ready), 0);
    pulse(1'b0);
    mode_at(20'h0, "R6 array after done", 0);
    chk("R6 wr_ready back", int'(wr_ready), 1);

    // R7 sector erase of sector 3
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h30000, 16'h0030);
    chk("R7 kind", int'(op_kind), 1);
    chk("R7 mask", int'(sect_mask), 'h0008);
    mode_at(20'h50000, "R7 status running", 1);
    wr(20'h00555, 16'h0090);
    mode_at(20'h50000, "R7 write ignored", 1);

    // R8 suspend
    wr(20'h00000, 16'h00B0);
    chk("R8 kind", int'(op_kind), 2);
    mode_at(20'h30010, "R8 suspended sector", 1);
    mode_at(20'h50000, "R8 other sector", 0);

    // R9 program while suspended
    unlock(); wr(20'h00555, 16'h00A0);
    wr(20'h50000, 16'h1234);
    chk("R9 kind", int'(op_kind), 0);
    mode_at(20'h50000, "R9 status running", 1);
    pulse(1'b0);
    mode_at(20'h30000, "R9 suspended sector after", 1);
    mode_at(20'h50000, "R9 other sector after", 0);

    // R10 resume
    wr(20'h00000, 16'h0030);
    chk("R10 kind", int'(op_kind), 3);
    mode_at(20'h50000, "R10 status resumed", 1);
    pulse(1'b0);
    mode_at(20'h30000, "R7 array after erase", 0);
    chk("R7 mask cleared", int'(sect_mask), 0);

    // R12 back-pressure with chip erase
    op_ready = 1'b0;
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h00555, 16'h0010);
    chk("R7 chip mask", int'(sect_mask), 'hFFFF);
    chk("R12 wr_ready low", int'(wr_ready), 0);
    repeat (3) @(negedge clk);
    chk("R12 held valid", int'(op_valid), 1);
    chk("R12 held kind", int'(op_kind), 1);
    op_ready = 1'b1;
    @(negedge clk);
    chk("R12 released", int'(op_valid), 0);
    chk("R12 wr_ready back", int'(wr_ready), 1);

    // R11 fault
    pulse(1'b1);
    mode_at(20'h50000, "R11 status", 1);
    unlock(); wr(20'h00555, 16'h0090);
    mode_at(20'h50000, "R11 writes ignored", 1);
    wr(20'h00000, 16'h00F0);
    mode_at(20'h50000, "R11 F0 recovers", 0);
    chk("R11 mask cleared", int'(sect_mask), 0);

    // R1 reset during autoselect
    unlock(); wr(20'h00555, 16'h0090);
    mode_at(20'h0, "R5 autoselect", 2);
    rst_n = 1'b0;
    #1;
    mode_at(20'h0, "R1 reset mid autoselect", 0);
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule